// File: doc/BRIEF.md
# Shared DMA Request Arbiter

This block decides which of two clients, the receive path or the transmit path, may use a single host DMA engine for its next transfer. Each client raises a request and holds it while it has work. When the engine is idle the arbiter grants exactly one client. The grant stays in place until the engine reports that the granted transfer, single or burst, has finished. The arbiter never looks at addresses, descriptors or data. It sees only the requests, a flag that says a transmit frame is on the wire, a policy bit, and the transfer-done pulse.

Two policies are offered. With the policy bit at 1, the two clients take turns whenever both wait. With the policy bit at 0, receive normally has fixed priority. While a transmit frame is in progress, however, the block forces the clients to take turns, so that neither can take two transfers in a row while the other is waiting. The block remembers which client it served last, and uses that to resolve contention.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, neither grant output is high.
- R2: At most one of `rx_gnt` and `tx_gnt` is high in any cycle.
- R3: Once a grant is high, it keeps its value on every clock edge at which `xfer_done` is low.
- R4: A clock edge with a grant high and `xfer_done` high clears both grants. The next arbitration takes place at the following edge.
- R5: With no grant high and only one client requesting, that client's grant rises at the next clock edge, whatever the policy bit and `tx_busy` are.
- R6: With `rr_mode`=1, no grant high and both clients requesting, the client that was not granted most recently wins.
- R7: After reset the receive client counts as favoured: if both clients request at the first arbitration, receive wins under either alternating rule.
- R8: With `rr_mode`=0, `tx_busy`=0, no grant high and both clients requesting, receive always wins.
- R9: With `rr_mode`=0, `tx_busy`=1, no grant high and both clients requesting, the client not granted most recently wins. Between two consecutive transfers of one client, a waiting request from the other client is therefore always served.
- R10: `xfer_done` pulses while no grant is high have no effect: grants and the record of the last-served client stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | Policy select: 1 = take turns, 0 = receive priority with alternation during a transmit frame |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_req | input | 1 | Receive client wants a transfer |
| tx_req | input | 1 | Transmit client wants a transfer |
| xfer_done | input | 1 | Pulse marking the end of the granted transfer |
| rx_gnt | output | 1 | Receive client owns the engine |
| tx_gnt | output | 1 | Transmit client owns the engine |

## Verification
The assertions assume that `xfer_done` means "end of the granted transfer" only while a grant is high, and that the policy bit and `tx_busy` are sampled at the arbitration edge only. They make no assumption about how long requests are held. The stimulus toggles requests, `tx_busy` and the policy bit freely, drops a request while its grant is active, and fires stray done pulses while idle. A behavioural reference model follows the grant history on every clock, so that alternation under contention is checked in both policies.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Registered arbitration state
    typedef struct packed {
        logic busy;     // a transfer is granted and not yet finished
        logic own_rx;   // owner of the current grant: 1 = receive, 0 = transmit
        logic last_rx;  // client served by the most recent grant: 1 = receive
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{busy: 1'b0, own_rx: 1'b0, last_rx: 1'b0};

endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick (
    input  logic rr_mode,
    input  logic tx_busy,
    input  logic rx_req,
    input  logic tx_req,
    input  logic last_rx,
    output logic want,
    output logic pick_rx
);

    logic turn_taking;

    always_comb begin
        // Turn-taking applies under round-robin or while a transmit frame runs
        turn_taking = rr_mode | tx_busy;
        want        = rx_req | tx_req;
        pick_rx     = 1'b0;
        if (rx_req && tx_req) begin
            pick_rx = turn_taking ? ~last_rx : 1'b1;
        end else if (rx_req) begin
            pick_rx = 1'b1;
        end
    end

endmodule

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl
    import dma_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want,
    input  logic       pick_rx,
    input  logic       xfer_done,
    output arb_state_t state
);

    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (xfer_done) begin
                st_d.busy   = 1'b0;
                st_d.own_rx = 1'b0;
            end
        end else if (want) begin
            st_d.busy    = 1'b1;
            st_d.own_rx  = pick_rx;
            st_d.last_rx = pick_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ARB_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rr_mode,
    input  logic tx_busy,
    input  logic rx_req,
    input  logic tx_req,
    input  logic xfer_done,
    output logic rx_gnt,
    output logic tx_gnt
);

    arb_state_t state;
    logic       want;
    logic       pick_rx;

    dma_arb_pick u_pick (
        .rr_mode (rr_mode),
        .tx_busy (tx_busy),
        .rx_req  (rx_req),
        .tx_req  (tx_req),
        .last_rx (state.last_rx),
        .want    (want),
        .pick_rx (pick_rx)
    );

    dma_arb_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .pick_rx   (pick_rx),
        .xfer_done (xfer_done),
        .state     (state)
    );

    assign rx_gnt = state.busy &  state.own_rx;
    assign tx_gnt = state.busy & ~state.own_rx;

    logic idle;
    assign idle = ~rx_gnt & ~tx_gnt;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_gnt, tx_gnt})); // R2

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !xfer_done) |=> ($stable(rx_gnt) && $stable(tx_gnt))); // R3

    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && xfer_done) |=> (!rx_gnt && !tx_gnt)); // R4

    AST_LONE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_req && !tx_req) |=> rx_gnt); // R5

    AST_LONE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tx_req && !rx_req) |=> tx_gnt); // R5

    AST_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_req && tx_req && rr_mode) |=> (rx_gnt != $past(state.last_rx))); // R6

    AST_RX_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_req && tx_req && !rr_mode && !tx_busy) |=> rx_gnt); // R8

    AST_TXFRAME_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_req && tx_req && !rr_mode && tx_busy) |=> (tx_gnt == $past(state.last_rx))); // R9

    AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !rx_req && !tx_req) |=> (idle && $stable(state.last_rx))); // R10

endmodule

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rr_mode = 1'b0;
    logic tx_busy = 1'b0;
    logic rx_req = 1'b0;
    logic tx_req = 1'b0;
    logic xfer_done = 1'b0;
    logic rx_gnt, tx_gnt;

    always #5 clk = ~clk;

    dma_req_arbiter u_dma_req_arbiter (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .tx_busy(tx_busy),
        .rx_req(rx_req), .tx_req(tx_req), .xfer_done(xfer_done),
        .rx_gnt(rx_gnt), .tx_gnt(tx_gnt)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Behavioural reference model
    int    owner = 0;        // 0 none, 1 receive, 2 transmit
    int    served_last = 2;  // receive favoured after reset
    bit    granted_once = 0;
    string why = "R1";
    int    since_reset = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner = 0; served_last = 2; granted_once = 0; why = "R1"; since_reset = 0;
        end else begin
            since_reset++;
            if (owner != 0) begin
                if (xfer_done) begin owner = 0; why = "R4"; end
                else why = "R3";
            end else if (rx_req || tx_req) begin
                if (rx_req && tx_req) begin
                    if (rr_mode) begin
                        owner = (served_last == 1) ? 2 : 1;
                        why = granted_once ? "R6" : "R7";
                    end else if (tx_busy) begin
                        owner = (served_last == 1) ? 2 : 1;
                        why = granted_once ? "R9" : "R7";
                    end else begin
                        owner = 1; why = "R8";
                    end
                end else begin
                    owner = rx_req ? 1 : 2; why = "R5";
                end
                served_last = owner;
                granted_once = 1;
            end else begin
                why = xfer_done ? "R10" : "R5";
            end
            if (since_reset == 1 && owner == 0) why = "R1";
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, then drive the next inputs
    always @(negedge clk) begin
        if (!finished) begin
            check(why, {30'd0, tx_gnt, rx_gnt}, (owner == 1) ? 1 : (owner == 2) ? 2 : 0);
            check("R2", int'(rx_gnt & tx_gnt), 0);
        end
    end

    task automatic step(input bit rm, input bit tb, input bit rq, input bit tq, input bit dn);
        @(negedge clk);
        #1;
        rr_mode = rm; tx_busy = tb; rx_req = rq; tx_req = tq; xfer_done = dn;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {30'd0, tx_gnt, rx_gnt}, 0);
        step(1, 0, 1, 1, 0);
        rst_n = 1'b1;
        // R7: first contention after reset goes to receive
        step(1, 0, 1, 1, 0);
        check("R7", int'(rx_gnt), 1);
        // R3: hold without done
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 1);
        check("R3", int'(rx_gnt), 1);
        // R6: after release, transmit's turn
        step(1, 0, 1, 1, 0);
        step(1, 0, 1, 1, 0);
        check("R6", int'(tx_gnt), 1);
        step(1, 0, 1, 1, 1);
        // R10: stray done while idle
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        check("R10", {30'd0, tx_gnt, rx_gnt}, 0);
        // R8: mode 0, no frame, receive wins twice in a row
        for (int k = 0; k < 2; k++) begin
            step(0, 0, 1, 1, 0);
            step(0, 0, 1, 1, 1);
            check("R8", int'(rx_gnt), 1);
        end
        // R9: mode 0 with frame active, alternation
        for (int k = 0; k < 4; k++) begin
            step(0, 1, 1, 1, 0);
            step(0, 1, 1, 1, 1);
            check("R9", int'(k % 2 == 0 ? tx_gnt : rx_gnt), 1);
        end
        // Random phases
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 2000; i++) begin
                bit rm, tb;
                rm = (ph == 0);
                tb = (ph == 2) ? 1'b1 : ($urandom_range(0, 3) == 0);
                step(rm, tb, $urandom_range(0, 1), $urandom_range(0, 1),
                     $urandom_range(0, 2) == 0);
            end
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule